// File: doc/BRIEF.md
# Multimode Asynchronous Serial Port

This block is an asynchronous serial transmitter and receiver. It is set up through one byte-wide control register, which holds the frame mode, the receive enable, the transmit and receive ninth bits, and two event flags. The frame is either 10 bits long (8 data bits) or 11 bits long (9 data bits). Both 9-bit modes can filter received frames, so that on a shared line in multiprocessor use only address frames raise the receive flag. In 8-bit mode the same filter bit drops frames whose stop bit is bad.

A host writes the data buffer to send a byte and reads the data buffer to collect the last frame that was accepted. The variable-rate modes are timed by a baud tick from outside the block, which runs at 16 times the bit rate. The fixed-rate 9-bit mode divides the system clock by 32 or by 64, chosen by an input. Both flags are set by hardware and are cleared only by writes from the host. The interrupt output is high while either flag is set.

Top module: `sp_uart`

## Requirements
- R1: The control register reads back as {mode[1:0], filt, rx_en, tx9, rx9, tx_flag, rx_flag}, from bit 7 down to bit 0. It resets to 0x00. A host write stores all eight bits; events from hardware then set rx9, tx_flag and rx_flag.
- R2: In mode 01 a data-buffer write sends a 10-bit frame on txd: a 0 start bit, the 8 data bits LSB first, then a 1 stop bit. Each bit lasts 16 baud ticks, and txd is 1 while idle.
- R3: In modes 10 and 11 the frame has 11 bits. The ninth data bit, taken from tx9, goes between data bit 7 and the stop bit.
- R4: In mode 10 a bit lasts 32 system clocks when div_fast is 1 and 64 when it is 0. The receiver uses the same timing.
- R5: tx_flag becomes 1 when the stop-bit period ends, not earlier. It stays 1 until a control write with bit 1 = 0.
- R6: With rx_en = 0 a frame on rxd changes neither rx_flag nor the receive buffer.
- R7: In mode 01 with filt = 0 a received frame loads its data into the receive buffer, copies the stop bit into rx9 and sets rx_flag. This includes a stop bit that reads 0.
- R8: In modes 10 and 11 an accepted frame loads its 8 data bits and copies the ninth bit into rx9.
- R9: In modes 10 and 11 with filt = 1, a frame whose ninth bit is 0 leaves rx_flag and the buffer unchanged. A frame whose ninth bit is 1 is accepted.
- R10: In mode 01 with filt = 1, a frame whose stop bit reads 0 is dropped, and one whose stop bit reads 1 is accepted.
- R11: irq is 1 exactly while tx_flag or rx_flag is 1.
- R12: A low pulse on rxd shorter than half a bit is taken as a false start. No frame is received, and the receiver accepts the next valid frame.
- R13: In mode 00 the port is inactive: a data-buffer write leaves txd at 1 and tx_flag at 0, and incoming frames are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| dat_we | input | 1 | Data buffer write strobe, starts a frame |
| dat_wdata | input | 8 | Byte to transmit |
| dat_rdata | output | 8 | Last accepted received byte |
| baud_x16 | input | 1 | One-clock tick at 16x the bit rate, for modes 01 and 11 |
| div_fast | input | 1 | Mode 10 divider: 1 = /32, 0 = /64 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Event output, high while a flag is set |

## Verification
The transmitter is tried with walking-one and walking-zero bytes and with all-zero, all-one and alternating bytes. A bit sent in the wrong order or a shift by one position changes the decoded frame. The same patterns are sent into the receiver in every mode and at both fixed divider settings, so a wrong bit period shows up as a wrong byte. The filter cases are tried over all combinations of ninth bit or stop bit against filt, which separates accepted frames from dropped ones. A 0xFE byte in mode 10 gives a low run two bits long, and measuring it pins down the divider. Short start glitches, disabled reception and mode 00 each check that nothing reaches the flags or the buffer.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;

  typedef enum logic [1:0] {
    MD_IDLE   = 2'b00,
    MD_U8     = 2'b01,
    MD_U9_FIX = 2'b10,
    MD_U9_VAR = 2'b11
  } sp_mode_e;

  typedef struct packed {
    sp_mode_e mode;
    logic     filt;
    logic     rx_en;
    logic     tx9;
    logic     rx9;
    logic     tx_flag;
    logic     rx_flag;
  } sp_ctl_t;

  function automatic logic is_nine(sp_mode_e m);
    return (m == MD_U9_FIX) || (m == MD_U9_VAR);
  endfunction

  // bits in one frame, start and stop included
  function automatic int unsigned frame_len(logic nine);
    return nine ? 11 : 10;
  endfunction

  function automatic logic vote3(logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

  // receive-flag gate: ninth-bit filter or stop-bit filter
  function automatic logic rx_keep(logic nine, logic filt, logic ninth, logic stop);
    if (nine) return !filt || ninth;
    return !filt || stop;
  endfunction

endpackage

// File: rtl/sp_tick_gen.sv
`timescale 1ns/1ps
module sp_tick_gen
  import sp_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int FAST_DIV = 32,
  parameter int SLOW_DIV = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sp_mode_e mode,
  input  logic     div_fast,
  input  logic     ext_tick,
  output logic     os_tick
);
  localparam int FAST_PC = FAST_DIV / OSR;
  localparam int SLOW_PC = SLOW_DIV / OSR;
  localparam int CW      = $clog2(SLOW_PC + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          fixed;

  assign fixed = (mode == MD_U9_FIX);
  assign lim   = div_fast ? CW'(FAST_PC - 1) : CW'(SLOW_PC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || !fixed) cnt <= '0;
    else if (cnt >= lim)  cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign os_tick = fixed ? (cnt >= lim) : ext_tick;
endmodule

// File: rtl/sp_tx.sv
`timescale 1ns/1ps
module sp_tx
  import sp_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       start,
  input  logic       nine,
  input  logic       tx9,
  input  logic [7:0] din,
  output logic       txd,
  output logic       busy,
  output logic       done
);
  localparam int OW = $clog2(OSR);
  localparam logic [OW-1:0] OS_LAST = OW'(OSR - 1);

  logic [10:0]   sh;
  logic [OW-1:0] os_cnt;
  logic [3:0]    bit_cnt;
  logic          nine_q;
  logic          bit_end;
  logic          last_bit;

  assign bit_end  = busy && os_tick && (os_cnt == OS_LAST);
  assign last_bit = (bit_cnt == 4'(frame_len(nine_q) - 1));
  assign done     = bit_end && last_bit && !start;
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '1;
      os_cnt  <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
      nine_q  <= 1'b0;
    end else if (start) begin
      sh      <= {1'b1, (nine ? tx9 : 1'b1), din, 1'b0};
      os_cnt  <= '0;
      bit_cnt <= '0;
      busy    <= 1'b1;
      nine_q  <= nine;
    end else if (busy && os_tick) begin
      if (os_cnt == OS_LAST) begin
        os_cnt <= '0;
        if (last_bit) begin
          busy <= 1'b0;
          sh   <= '1;
        end else begin
          sh      <= {1'b1, sh[10:1]};
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        os_cnt <= os_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_rx.sv
`timescale 1ns/1ps
module sp_rx
  import sp_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       en,
  input  logic       nine,
  input  logic       rxd_s,
  output logic       frame_end,
  output logic [7:0] data,
  output logic       ninth,
  output logic       stop
);
  localparam int MID = OSR / 2;
  localparam int OW  = $clog2(OSR);
  localparam logic [OW-1:0] V0      = OW'(MID - 1);
  localparam logic [OW-1:0] V1      = OW'(MID);
  localparam logic [OW-1:0] V2      = OW'(MID + 1);
  localparam logic [OW-1:0] OS_LAST = OW'(OSR - 1);

  logic          active, armed, nine_q;
  logic [OW-1:0] os_cnt;
  logic [3:0]    bit_cnt;
  logic [1:0]    smp;
  logic [8:0]    sh;
  logic          vote_now, v, is_last;

  assign vote_now  = active && os_tick && (os_cnt == V2);
  assign v         = vote3({rxd_s, smp});
  assign is_last   = (bit_cnt == 4'(frame_len(nine_q) - 1));
  assign frame_end = vote_now && en && is_last;
  assign stop      = v;
  assign data      = nine_q ? sh[7:0] : sh[8:1];
  assign ninth     = sh[8];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      armed   <= 1'b0;
      nine_q  <= 1'b0;
      os_cnt  <= '0;
      bit_cnt <= '0;
      smp     <= '0;
      sh      <= '0;
    end else if (!en) begin
      active <= 1'b0;
      armed  <= 1'b0;
    end else if (!active) begin
      if (os_tick) begin
        if (rxd_s) armed <= 1'b1;
        else if (armed) begin
          active  <= 1'b1;
          armed   <= 1'b0;
          os_cnt  <= OW'(1);
          bit_cnt <= '0;
          nine_q  <= nine;
        end
      end
    end else if (os_tick) begin
      if (os_cnt == V0) smp[0] <= rxd_s;
      if (os_cnt == V1) smp[1] <= rxd_s;
      if (os_cnt == V2) begin
        if (bit_cnt == 4'd0) begin
          if (v) active <= 1'b0;
        end else if (is_last) begin
          active <= 1'b0;
        end else begin
          sh <= {v, sh[8:1]};
        end
      end
      if (os_cnt == OS_LAST) begin
        os_cnt  <= '0;
        bit_cnt <= bit_cnt + 1'b1;
      end else begin
        os_cnt <= os_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_uart.sv
`timescale 1ns/1ps
module sp_uart
  import sp_pkg::*;
#(
  parameter int OSR      = 16,
  parameter int FAST_DIV = 32,
  parameter int SLOW_DIV = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       dat_we,
  input  logic [7:0] dat_wdata,
  output logic [7:0] dat_rdata,
  input  logic       baud_x16,
  input  logic       div_fast,
  input  logic       rxd,
  output logic       txd,
  output logic       irq
);
  sp_ctl_t    ctl;
  logic [1:0] rxd_sync;
  logic [7:0] rbuf;
  logic       os_tick, active_mode;
  logic       tx_start, tx_busy, tx_done;
  logic       rx_end, rx_ninth, rx_stop, rx_accept;
  logic [7:0] rx_data;

  assign active_mode = (ctl.mode != MD_IDLE);
  assign tx_start    = dat_we && active_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) rxd_sync <= 2'b11;
    else        rxd_sync <= {rxd_sync[0], rxd};
  end

  sp_tick_gen #(.OSR(OSR), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(ctl.mode), .div_fast(div_fast),
    .ext_tick(baud_x16), .os_tick(os_tick)
  );

  sp_tx #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .start(tx_start),
    .nine(is_nine(ctl.mode)), .tx9(ctl.tx9), .din(dat_wdata),
    .txd(txd), .busy(tx_busy), .done(tx_done)
  );

  sp_rx #(.OSR(OSR)) u_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .en(ctl.rx_en && active_mode), .nine(is_nine(ctl.mode)),
    .rxd_s(rxd_sync[1]), .frame_end(rx_end), .data(rx_data),
    .ninth(rx_ninth), .stop(rx_stop)
  );

  assign rx_accept = rx_end && rx_keep(is_nine(ctl.mode), ctl.filt, rx_ninth, rx_stop);

  // hardware set events take priority over a same-cycle host write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl  <= '0;
      rbuf <= '0;
    end else begin
      if (ctl_we) ctl <= sp_ctl_t'(ctl_wdata);
      if (tx_done) ctl.tx_flag <= 1'b1;
      if (rx_accept) begin
        ctl.rx_flag <= 1'b1;
        ctl.rx9     <= is_nine(ctl.mode) ? rx_ninth : rx_stop;
        rbuf        <= rx_data;
      end
    end
  end

  assign ctl_rdata = ctl;
  assign dat_rdata = rbuf;
  assign irq       = ctl.tx_flag | ctl.rx_flag;
endmodule

// File: rtl/sp_uart_chk.sv
`timescale 1ns/1ps
module sp_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       txd,
  input logic       irq,
  input logic       tx_busy,
  input logic       tx_done,
  input logic       rx_end,
  input logic       rx_accept,
  input logic       rx_ninth,
  input logic       rx_stop
);
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  // R5
  tx_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_rdata[1]) |-> $past(ctl_we) && !$past(ctl_wdata[1]));

  // R5
  tx_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_rdata[1]) |-> $past(tx_done) || $past(ctl_we && ctl_wdata[1]));

  // R6
  rx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> ctl_rdata[4]);

  // R9
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept && ctl_rdata[7] && ctl_rdata[5] |-> rx_ninth);

  // R10
  stop_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept && (ctl_rdata[7:6] == 2'b01) && ctl_rdata[5] |-> rx_stop);

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tx_done || rx_accept || ctl_we));
endmodule

bind sp_uart sp_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .txd(txd), .irq(irq), .tx_busy(tx_busy),
  .tx_done(tx_done), .rx_end(rx_end), .rx_accept(rx_accept),
  .rx_ninth(rx_ninth), .rx_stop(rx_stop)
);

// File: tb/sim_sp_uart.sv
`timescale 1ns/1ps
module sim_sp_uart;
  logic       clk = 1'b0;
  logic       rst_n, ctl_we, dat_we, baud_x16, div_fast, rxd;
  logic [7:0] ctl_wdata, dat_wdata, ctl_rdata, dat_rdata;
  logic       txd, irq;
  int         vecs = 0;
  int         errs = 0;
  int         tdiv = 0;
  localparam int PV = 48; // variable modes: tick every 3 clocks, 16 ticks per bit

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (tdiv == 2) begin tdiv = 0; baud_x16 = 1'b1; end
    else begin tdiv = tdiv + 1; baud_x16 = 1'b0; end
  end

  sp_uart u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
    .dat_rdata(dat_rdata), .baud_x16(baud_x16), .div_fast(div_fast),
    .rxd(rxd), .txd(txd), .irq(irq)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic write_dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    if (i < 8)  return 8'(1 << i);
    if (i < 16) return ~8'(1 << (i - 8));
    case (i)
      16: return 8'h00;
      17: return 8'hFF;
      18: return 8'h55;
      default: return 8'hA5;
    endcase
  endfunction

  task automatic tx_check(input logic [1:0] md, input logic [7:0] d, input logic b9,
                          input int P, input string req);
    logic [10:0] exp, got;
    int n;
    n   = md[1] ? 11 : 10;
    exp = md[1] ? {1'b1, b9, d, 1'b0} : {2'b11, d, 1'b0};
    got = '1;
    write_ctl({md, 2'b00, b9, 3'b000});
    write_dat(d);
    wait_clk(P / 2);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      wait_clk(P);
      got[i] = txd;
    end
    check(ctl_rdata[1] == 1'b0, "R5 flag early", 32'(ctl_rdata[1]), 0);
    wait_clk(P / 2 + 2);
    check(got == exp, req, 32'(got), 32'(exp));
    check(ctl_rdata[1] == 1'b1, "R5 flag after stop", 32'(ctl_rdata[1]), 1);
    check(irq == 1'b1, "R11 irq with tx flag", 32'(irq), 1);
    write_ctl({md, 6'b000000});
    check(ctl_rdata[1] == 1'b0 && irq == 1'b0, "R5 clear by write", 32'({ctl_rdata[1], irq}), 0);
  endtask

  task automatic tx_low(input int P);
    int cnt, pc;
    pc = P / 16;
    cnt = 0;
    write_ctl(8'b1000_0000);
    write_dat(8'hFE);
    while (txd == 1'b0 && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt >= 2 * P - pc - 1 && cnt <= 2 * P + 1, "R4 bit period", 32'(cnt), 32'(2 * P));
    wait_clk(11 * P);
    write_ctl(8'b1000_0000);
  endtask

  task automatic rx_check(input logic [1:0] md, input logic filt, input logic en,
                          input logic [7:0] d, input logic b9, input logic stopv,
                          input int P, input logic acc, input string req);
    logic [10:0] fr;
    logic [7:0]  prev;
    int n;
    write_ctl({md, filt, en, 4'b0000});
    wait_clk(P);
    prev = dat_rdata;
    n  = md[1] ? 11 : 10;
    fr = md[1] ? {stopv, b9, d, 1'b0} : {1'b1, stopv, d, 1'b0};
    for (int i = 0; i < n; i++) begin
      rxd = fr[i];
      wait_clk(P);
    end
    rxd = 1'b1;
    wait_clk(P);
    if (acc) begin
      check(ctl_rdata[0] == 1'b1, req, 32'(ctl_rdata[0]), 1);
      check(dat_rdata == d, req, 32'(dat_rdata), 32'(d));
      check(ctl_rdata[2] == (md[1] ? b9 : stopv), req, 32'(ctl_rdata[2]), 32'(md[1] ? b9 : stopv));
      check(irq == 1'b1, "R11 irq with rx flag", 32'(irq), 1);
    end else begin
      check(ctl_rdata[0] == 1'b0, req, 32'(ctl_rdata[0]), 0);
      check(dat_rdata == prev, req, 32'(dat_rdata), 32'(prev));
    end
  endtask

  logic finished = 1'b0;

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_we = 1'b0; dat_we = 1'b0; ctl_wdata = '0; dat_wdata = '0;
    div_fast = 1'b1; rxd = 1'b1;
    wait_clk(6);
    check(ctl_rdata == 8'h00, "R1 reset value", 32'(ctl_rdata), 0);
    check(txd == 1'b1 && irq == 1'b0, "R1 reset lines", 32'({txd, irq}), 2);
    rst_n = 1'b1;
    wait_clk(4);

    write_ctl(8'hFF);
    check(ctl_rdata == 8'hFF, "R1 readback", 32'(ctl_rdata), 32'hFF);
    check(irq == 1'b1, "R11 irq follows flags", 32'(irq), 1);
    write_ctl(8'h00);
    check(ctl_rdata == 8'h00 && irq == 1'b0, "R1 R11 cleared", 32'({ctl_rdata, irq}), 0);

    for (int i = 0; i < 20; i++) tx_check(2'b01, pat(i), 1'b0, PV, "R2 frame mode 01");
    for (int i = 0; i < 8; i++)  tx_check(2'b11, pat(i + 12), 1'(i), PV, "R3 frame mode 11");
    div_fast = 1'b1;
    for (int i = 0; i < 4; i++)  tx_check(2'b10, pat(i + 16), 1'(i + 1), 32, "R3 R4 frame mode 10 fast");
    tx_low(32);
    div_fast = 1'b0;
    for (int i = 0; i < 4; i++)  tx_check(2'b10, pat(i * 3), 1'(i), 64, "R3 R4 frame mode 10 slow");
    tx_low(64);

    for (int i = 0; i < 20; i++) rx_check(2'b01, 1'b0, 1'b1, pat(i), 1'b0, 1'b1, PV, 1'b1, "R7 receive mode 01");
    for (int i = 0; i < 8; i++)  rx_check(2'b11, 1'b0, 1'b1, pat(i + 8), 1'(i), 1'b1, PV, 1'b1, "R8 receive mode 11");
    div_fast = 1'b1;
    for (int i = 0; i < 3; i++)  rx_check(2'b10, 1'b0, 1'b1, pat(i + 16), 1'(i), 1'b1, 32, 1'b1, "R4 R8 receive mode 10 fast");
    div_fast = 1'b0;
    for (int i = 0; i < 3; i++)  rx_check(2'b10, 1'b0, 1'b1, pat(i + 5), 1'(i + 1), 1'b1, 64, 1'b1, "R4 R8 receive mode 10 slow");

    rx_check(2'b11, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b1, PV, 1'b0, "R9 data frame dropped");
    rx_check(2'b11, 1'b1, 1'b1, 8'hC3, 1'b1, 1'b1, PV, 1'b1, "R9 address frame kept");
    rx_check(2'b11, 1'b0, 1'b1, 8'h5A, 1'b0, 1'b1, PV, 1'b1, "R9 filter off");
    rx_check(2'b10, 1'b1, 1'b1, 8'h66, 1'b0, 1'b1, 64, 1'b0, "R9 data frame dropped mode 10");
    rx_check(2'b01, 1'b1, 1'b1, 8'h99, 1'b0, 1'b0, PV, 1'b0, "R10 bad stop dropped");
    rx_check(2'b01, 1'b1, 1'b1, 8'h71, 1'b0, 1'b1, PV, 1'b1, "R10 good stop kept");
    rx_check(2'b01, 1'b0, 1'b1, 8'h17, 1'b0, 1'b0, PV, 1'b1, "R7 bad stop kept without filter");
    rx_check(2'b01, 1'b0, 1'b0, 8'hE8, 1'b0, 1'b1, PV, 1'b0, "R6 receiver disabled");

    // R12: short start pulse
    write_ctl(8'b0101_0000);
    wait_clk(PV);
    begin
      logic [7:0] prev;
      prev = dat_rdata;
      rxd = 1'b0; wait_clk(PV / 4);
      rxd = 1'b1; wait_clk(12 * PV);
      check(ctl_rdata[0] == 1'b0, "R12 glitch no flag", 32'(ctl_rdata[0]), 0);
      check(dat_rdata == prev, "R12 glitch buffer kept", 32'(dat_rdata), 32'(prev));
    end
    rx_check(2'b01, 1'b0, 1'b1, 8'h4D, 1'b0, 1'b1, PV, 1'b1, "R12 recovery frame");

    // R13: inactive mode
    write_ctl(8'b0001_0000);
    write_dat(8'h00);
    begin
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < 3 * PV; i++) begin
        if (txd == 1'b0) ok = 1'b0;
        @(negedge clk);
      end
      check(ok, "R13 txd stays idle", 32'(ok), 1);
      check(ctl_rdata[1] == 1'b0, "R13 no tx flag", 32'(ctl_rdata[1]), 0);
    end
    rx_check(2'b00, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1, PV, 1'b0, "R13 receive ignored");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule